// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

A synchronous reversible counter of four bits. A parameter selects between a natural binary sequence (0 to 15) and a decimal sequence (0 to 9, 8-4-2-1 code). Every state bit changes on the same rising clock edge. The count moves only while the active-low count enable is asserted. A direction input selects up or down counting.

An active-low load input presets the counter from the data inputs at once, without waiting for a clock edge. This allows modulo-N division by presetting the start value.

Two outputs support chaining stages:
- A terminal-count flag marks the overflow or underflow point for the current direction.
- An active-low ripple pulse is the terminal-count flag gated with the enable and the low phase of the clock. It is fed to the enable of the next, more significant stage.

Top module: `cascade_counter`

## Requirements
- R1: With cnt_en_ni high, the count holds. The count changes only on a rising edge of clk_i that sees cnt_en_ni low, with load_ni and rst_ni both high.
- R2: dir_down_i low (0) counts up and dir_down_i high (1) counts down. In binary mode the count wraps from 15 to 0 going up and from 0 to 15 going down.
- R3: In decimal mode (BCD=1) the count stays within 0..9. It wraps from 9 to 0 going up and from 0 to 9 going down.
- R4: In decimal mode, a loaded value of 10..15 leaves the illegal range at the next enabled edge. Counting up it goes to 0, and counting down it goes to 9.
- R5: While load_ni is low, count_o equals data_i, with no clock edge needed, and counting is overridden. data_i is held stable while load_ni is low. After load_ni returns high, counting resumes from the loaded value at the next enabled rising edge.
- R6: tc_o is high exactly in two cases: counting up at the top value (15 in binary, 9 in decimal), or counting down at 0. It is low in every other case, including illegal decimal values.
- R7: ripple_no is low exactly when tc_o is high, cnt_en_ni is low and clk_i is low. It is high in every other case.
- R8: rst_ni low clears count_o to 0 at once, whatever the clock is doing.
- R9: Two binary stages can be chained as one counter running in both directions. The lower stage's ripple_no drives the upper stage's cnt_en_ni, and both stages share the clock and direction. The chained value is {upper, lower}, and it counts modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the count |
| cnt_en_ni | input | 1 | Count enable, active low |
| dir_down_i | input | 1 | Direction: 0 up, 1 down |
| load_ni | input | 1 | Asynchronous parallel preset, active low |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal count (max when up, min when down) |
| ripple_no | output | 1 | Cascade pulse, active low, in the clock's low phase |

## Verification
The assertions assume three things about the inputs:
- cnt_en_ni and dir_down_i change only while clk_i is high.
- data_i stays constant for as long as load_ni is held low.
- load_ni and rst_ni change away from the rising edge.

The stimulus drives every input change 1 ns after a rising edge, inside the 2 ns high phase, and it counts a failure if the clock is ever found low at that point. The upper stage in the chain receives the lower stage's ripple output after a 1 ns wire delay. With that delay, the enable the upper stage sees at an edge is the value the ripple output had in the low phase just before that edge.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/cnt_step.sv
module cnt_step #(
  parameter int unsigned WIDTH = 4,
  parameter bit          BCD   = 1'b0
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             dir_down_i,
  output logic [WIDTH-1:0] nxt_o
);
  import cascade_counter_pkg::*;

  localparam int unsigned MAXV = BCD ? 9 : (1 << WIDTH) - 1;
  localparam logic [WIDTH-1:0] MAX_Q = MAXV[WIDTH-1:0];

  dir_e dir;
  assign dir = dir_e'(dir_down_i);

  always_comb begin
    if (dir == DIR_UP) begin
      // top value and any illegal code fold to zero
      nxt_o = (q_i >= MAX_Q) ? '0 : q_i + 1'b1;
    end else if (q_i == '0 || q_i > MAX_Q) begin
      nxt_o = MAX_Q;
    end else begin
      nxt_o = q_i - 1'b1;
    end
  end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int unsigned WIDTH = 4,
  parameter bit          BCD   = 1'b0
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             dir_down_i,
  output logic             tc_o
);
  localparam int unsigned MAXV = BCD ? 9 : (1 << WIDTH) - 1;
  localparam logic [WIDTH-1:0] MAX_Q = MAXV[WIDTH-1:0];

  logic at_top, at_bottom;
  assign at_top    = (q_i == MAX_Q);
  assign at_bottom = (q_i == '0);
  assign tc_o      = dir_down_i ? at_bottom : at_top;
endmodule

// File: rtl/cnt_ripple.sv
module cnt_ripple (
  input  logic clk_i,
  input  logic tc_i,
  input  logic cnt_en_ni,
  output logic ripple_no
);
  // low only during the low phase of the clock
  assign ripple_no = ~(tc_i & ~cnt_en_ni & ~clk_i);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int unsigned WIDTH = 4,
  parameter bit          BCD   = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_ni,
  input  logic             dir_down_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o,
  output logic             ripple_no
);
  logic [WIDTH-1:0] q, nxt;

  cnt_step #(.WIDTH(WIDTH), .BCD(BCD)) u_step (
    .q_i       (q),
    .dir_down_i(dir_down_i),
    .nxt_o     (nxt)
  );

  cnt_term #(.WIDTH(WIDTH), .BCD(BCD)) u_term (
    .q_i       (q),
    .dir_down_i(dir_down_i),
    .tc_o      (tc_o)
  );

  cnt_ripple u_ripple (
    .clk_i    (clk_i),
    .tc_i     (tc_o),
    .cnt_en_ni(cnt_en_ni),
    .ripple_no(ripple_no)
  );

  // preset is asynchronous; data_i must stay stable while load_ni is low
  always_ff @(posedge clk_i or negedge rst_ni or negedge load_ni) begin
    if (!rst_ni)         q <= '0;
    else if (!load_ni)   q <= data_i;
    else if (!cnt_en_ni) q <= nxt;
  end

  assign count_o = q;
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int unsigned WIDTH = 4,
  parameter bit          BCD   = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_ni,
  input logic             dir_down_i,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o,
  input logic             ripple_no
);
  localparam int unsigned MAXV = BCD ? 9 : (1 << WIDTH) - 1;
  localparam logic [WIDTH-1:0] MAX_Q = MAXV[WIDTH-1:0];

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || !load_ni)
    ($past(load_ni) && $past(rst_ni) && $past(cnt_en_ni)) |-> $stable(count_o));

  a_r2_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni || !load_ni)
    ($past(load_ni) && $past(rst_ni) && !$past(cnt_en_ni) && !$past(dir_down_i)
     && $past(count_o) < MAX_Q) |-> count_o == $past(count_o) + 1'b1);

  a_r2_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni || !load_ni)
    ($past(load_ni) && $past(rst_ni) && !$past(cnt_en_ni) && $past(dir_down_i)
     && $past(count_o) != '0 && $past(count_o) <= MAX_Q) |-> count_o == $past(count_o) - 1'b1);

  a_r3_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni || !load_ni)
    ($past(load_ni) && $past(rst_ni) && !$past(cnt_en_ni) && !$past(dir_down_i)
     && $past(count_o) == MAX_Q) |-> count_o == '0);

  a_r4_back_to_legal: assert property (@(posedge clk_i) disable iff (!rst_ni || !load_ni)
    ($past(load_ni) && $past(rst_ni) && !$past(cnt_en_ni)) |-> count_o <= MAX_Q);

  a_r5_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |-> count_o == data_i);

  a_r6_tc_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (count_o == '0 || count_o == MAX_Q));

  a_r7_ripple_low_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ripple_no == !(tc_o && !cnt_en_ni));

  a_r7_ripple_high_phase: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ripple_no);

  a_r8_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == '0);
endmodule

bind cascade_counter cascade_counter_chk #(.WIDTH(WIDTH), .BCD(BCD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_en_ni (cnt_en_ni),
  .dir_down_i(dir_down_i),
  .load_ni   (load_ni),
  .data_i    (data_i),
  .count_o   (count_o),
  .tc_o      (tc_o),
  .ripple_no (ripple_no)
);

// File: tb/tb_cascade_counter.sv
`timescale 1ns/1ps
module tb_cascade_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic en_n = 1'b1, dn = 1'b0, load_n = 1'b1;
  logic [7:0] data8 = '0;
  logic [3:0] lo_cnt, hi_cnt;
  logic lo_tc, lo_rn, hi_tc, hi_rn;
  logic hi_en_n = 1'b1;

  logic b_en_n = 1'b1, b_dn = 1'b0, b_load_n = 1'b1;
  logic [3:0] b_data = '0, b_cnt;
  logic b_tc, b_rn;

  int total = 0, bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  cascade_counter #(.WIDTH(4), .BCD(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_ni(en_n), .dir_down_i(dn),
    .load_ni(load_n), .data_i(data8[3:0]), .count_o(lo_cnt), .tc_o(lo_tc), .ripple_no(lo_rn));

  // wire delay so the upper stage sees the pre-edge ripple level at the edge
  always @(lo_rn) hi_en_n <= #1 lo_rn;

  cascade_counter #(.WIDTH(4), .BCD(1'b0)) stage_hi (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_ni(hi_en_n), .dir_down_i(dn),
    .load_ni(load_n), .data_i(data8[7:4]), .count_o(hi_cnt), .tc_o(hi_tc), .ripple_no(hi_rn));

  cascade_counter #(.WIDTH(4), .BCD(1'b1)) u_bcd (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_ni(b_en_n), .dir_down_i(b_dn),
    .load_ni(b_load_n), .data_i(b_data), .count_o(b_cnt), .tc_o(b_tc), .ripple_no(b_rn));

  typedef struct {
    logic [7:0] val;
    logic       tc;
    logic       rn;
    string      req;
  } item_t;
  item_t sb_q[$];
  logic [7:0] m8 = '0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus, pushes what the monitor must see in the low phase
  task automatic step(input logic en_v, input logic dn_v, input string req);
    item_t it;
    @(posedge clk); #1;
    chk("R1 stimulus in high phase", {7'd0, clk}, 8'd1);
    en_n = en_v; dn = dn_v;
    it.val = m8;
    it.tc  = dn_v ? (m8[3:0] == 4'd0) : (m8[3:0] == 4'd15);
    it.rn  = !(it.tc && !en_v);
    it.req = req;
    sb_q.push_back(it);
    if (!en_v) m8 = dn_v ? m8 - 8'd1 : m8 + 8'd1;
  endtask

  // monitor
  initial forever begin
    @(posedge clk); #3;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk({it.req, " R9 chained count"}, {hi_cnt, lo_cnt}, it.val);
      chk({it.req, " R6 tc"}, {7'd0, lo_tc}, {7'd0, it.tc});
      chk({it.req, " R7 ripple"}, {7'd0, lo_rn}, {7'd0, it.rn});
    end
  end

  task automatic do_load(input logic [7:0] v);
    @(posedge clk); #1;
    load_n = 1'b0; data8 = v; en_n = 1'b0;
    #0.5 chk("R5 async preset", {hi_cnt, lo_cnt}, v);
    @(posedge clk); #1;
    chk("R5 load overrides count", {hi_cnt, lo_cnt}, v);
    en_n = 1'b1; load_n = 1'b1;
    m8 = v;
  endtask

  logic [3:0] bm = '0;
  task automatic bstep(input logic en_v, input logic dn_v, input string req);
    logic t;
    @(posedge clk); #1;
    b_en_n = en_v; b_dn = dn_v;
    #0.5 chk("R7 bcd ripple high phase", {7'd0, b_rn}, 8'd1);
    #1.5;
    t = dn_v ? (bm == 4'd0) : (bm == 4'd9);
    chk({req, " bcd count"}, {4'd0, b_cnt}, {4'd0, bm});
    chk("R6 bcd tc", {7'd0, b_tc}, {7'd0, t});
    chk("R7 bcd ripple", {7'd0, b_rn}, {7'd0, !(t && !en_v)});
    if (!en_v) begin
      if (!dn_v) bm = (bm >= 4'd9) ? 4'd0 : bm + 4'd1;
      else       bm = (bm == 4'd0 || bm > 4'd9) ? 4'd9 : bm - 4'd1;
    end
  endtask

  task automatic bload(input logic [3:0] v);
    @(posedge clk); #1;
    b_en_n = 1'b1; b_load_n = 1'b0; b_data = v;
    #0.5 chk("R5 bcd async preset", {4'd0, b_cnt}, {4'd0, v});
    @(posedge clk); #1;
    b_load_n = 1'b1;
    bm = v;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R8 reset state", {hi_cnt, lo_cnt}, 8'h00);
    chk("R8 bcd reset state", {4'd0, b_cnt}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R1 hold");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R2 up");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R1 hold");
    for (int i = 0; i < 25; i++) step(1'b0, 1'b1, "R2 down wrap");
    step(1'b1, 1'b0, "R1 hold");
    do_load(8'hF3);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, "R9 up across 0xFF");
    do_load(8'h05);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, "R9 down across 0x00");
    do_load(8'h1E);
    for (int i = 0; i < 30; i++) step(i % 3 == 0, (i / 7) % 2 == 1, "R1 mixed");
    step(1'b1, 1'b0, "R5 settle");

    // asynchronous reset mid-run
    @(posedge clk); #1;
    en_n = 1'b1; rst_n = 1'b0;
    #0.5 chk("R8 async clear", {hi_cnt, lo_cnt}, 8'h00);
    @(posedge clk); #1 rst_n = 1'b1; m8 = '0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R2 down from 0");

    // decimal instance
    bload(4'd0);
    for (int i = 0; i < 12; i++) bstep(1'b0, 1'b0, "R3 up");
    for (int i = 0; i < 12; i++) bstep(1'b0, 1'b1, "R3 down");
    bload(4'd12);
    bstep(1'b0, 1'b0, "R4 illegal up");
    bstep(1'b0, 1'b0, "R4 after illegal up");
    bload(4'd14);
    bstep(1'b0, 1'b1, "R4 illegal down");
    bstep(1'b0, 1'b1, "R4 after illegal down");
    bload(4'd15);
    bstep(1'b1, 1'b0, "R1 bcd hold");
    bstep(1'b0, 1'b1, "R4 15 down");
    bstep(1'b0, 1'b1, "R4 after 15 down");

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule